// File: doc/BRIEF.md
# Carrier PWM Channel with Update-Instant Duty Latching

This block is one PWM channel for a power converter controller. It advances a carrier counter on timing ticks taken from one of four time-base sources, shapes that counter into either a sawtooth (single-edge) or a triangular (double-edge) carrier, and compares it with an active duty value to drive the switch output. All four sources are single-cycle enable pulses in the one system clock domain. Source 0 is normally the fixed main time base. Sources 1 to 3 may run at any integer or non-integer ratio of it, and their rate may vary.

The control side writes duty values into a shadow register at any time. The block moves the shadow value into the active compare register only at the legal update instants of the carrier in use. A sawtooth carrier has one such instant, its restart. A triangular carrier has two, its valley and its peak. The triangular case is what makes double-rate update possible: the carrier runs at half the rate of the sampling and interrupt time base, so a new duty value lands twice per switching period. The single-rate case runs sampling, control and duty update all at the switching rate from one time base.

A pulse marks each update instant so that acquisition and control scheduling can align to it. The carrier period and the carrier shape are also taken only at a restart. A change of rate on a variable source therefore never breaks a carrier cycle.

Top module: `carrier_pwm`

## Requirements
- R1: While reset is asserted and right after it, `pwm_out`, `upd_valley` and `upd_peak` are low. The active duty, the shadow duty and the carrier are 0, the latched period is 2 and the latched shape is sawtooth.
- R2: The carrier advances only on a system clock edge where the source bit picked by `src_sel` (index 0 to 3) is high. Ticks on the unselected sources have no effect on the output or on the events.
- R3: With a sawtooth carrier (`carrier_tri` = 0 latched) and latched period P, the carrier steps through 0, 1, … P-1 and then restarts at 0. That is P ticks per period. Each restart gives one `upd_valley` pulse, and `upd_peak` never pulses.
- R4: With a triangular carrier (`carrier_tri` = 1 latched), the carrier rises from 0 to P and then falls back to 0, taking 2P ticks. Reaching P gives one `upd_peak` pulse, and returning to 0 gives one `upd_valley` pulse.
- R5: The active duty changes only at an update instant. Those instants are the restart for a sawtooth carrier, and the peak and the valley for a triangular carrier. At such an instant the active duty takes the current shadow value.
- R6: Each `duty_wr` pulse overwrites the shadow register. When several writes happen between two update instants, only the last one is transferred. A write on the same edge as a transfer goes to the next instant.
- R7: `pwm_out` is high while the carrier value is below the active duty.
- R8: An active duty of 0 keeps `pwm_out` low. An active duty at or above the latched period keeps `pwm_out` high for the whole period, carrier peak included.
- R9: `period` and `carrier_tri` are sampled only at a restart and hold until the next one. A period below 2 is taken as 2.
- R10: `upd_valley` and `upd_peak` are each one system clock wide. They are high in the cycle right after the tick edge that reaches the instant, and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC (4) | Per-source time-base tick enables |
| src_sel | input | SEL_W (2) | Index of the time-base source that drives the carrier |
| carrier_tri | input | 1 | Requested carrier shape: 1 triangular, 0 sawtooth |
| period | input | CNT_W (16) | Requested carrier period P in ticks |
| duty | input | CNT_W (16) | Duty value written to the shadow register |
| duty_wr | input | 1 | Write strobe for `duty` |
| pwm_out | output | 1 | Switch drive output |
| upd_valley | output | 1 | Pulse at each carrier restart (valley) |
| upd_peak | output | 1 | Pulse at each triangular carrier peak |

## Verification
Directed runs first exercise each carrier shape alone with ticks on every cycle. This separates the P-tick restart rhythm of the sawtooth from the 2P-tick triangle and its extra peak instant. Bursts of ticks only on unselected sources show whether the source select truly gates the carrier. Duty writes placed mid-period, doubled, or on the same edge as an update instant distinguish shadow latching from direct writes. Duties of 0 and above the period probe the two saturated outputs. Period and shape changes requested mid-period reveal whether they wait for the restart. A long run with seeded random ticks, source switches, writes and reconfigurations then checks the output and both event lines against an index-based carrier model every cycle.

// File: rtl/carrier_pwm_pkg.sv
package carrier_pwm_pkg;

   typedef enum logic {
      CAR_SAW = 1'b0,
      CAR_TRI = 1'b1
   } carrier_e;

   typedef struct packed {
      logic restart;
      logic peak;
   } upd_evt_t;

endpackage

// File: rtl/pwm_tick_mux.sv
module pwm_tick_mux #(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);

   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = src_tick[i] & (sel == SEL_W'(i));
   end

   assign tick = |hit;

endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier
   import carrier_pwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int MIN_PER = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             tri_req,
   input  logic [CNT_W-1:0] period_req,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] per_act,
   output upd_evt_t         xfer,
   output logic             upd_valley,
   output logic             upd_peak
);

   localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PER);

   carrier_e         mode_q;
   logic             dir_up;
   logic [CNT_W-1:0] per_clamp;
   logic             at_top;
   logic             at_floor;

   assign per_clamp = (period_req < MIN_P) ? MIN_P : period_req;
   assign at_top    = (cnt >= per_act - CNT_W'(1));
   assign at_floor  = (cnt <= CNT_W'(1));

   always_comb begin
      xfer.restart = 1'b0;
      xfer.peak    = 1'b0;
      if (tick) begin
         if (mode_q == CAR_SAW) begin
            xfer.restart = at_top;
         end else if (dir_up) begin
            xfer.peak = at_top;
         end else begin
            xfer.restart = at_floor;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         per_act    <= MIN_P;
         mode_q     <= CAR_SAW;
         dir_up     <= 1'b1;
         upd_valley <= 1'b0;
         upd_peak   <= 1'b0;
      end else begin
         upd_valley <= xfer.restart;
         upd_peak   <= xfer.peak;
         if (xfer.restart) begin
            cnt     <= '0;
            dir_up  <= 1'b1;
            per_act <= per_clamp;
            mode_q  <= carrier_e'(tri_req);
         end else if (xfer.peak) begin
            cnt    <= per_act;
            dir_up <= 1'b0;
         end else if (tick) begin
            cnt <= dir_up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
         end
      end
   end

   // R4: carrier never leaves 0..P (and 0..P-1 for a sawtooth, R3)
   assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act);
   assert_saw_below_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CAR_SAW) |-> (cnt < per_act));
   // R3: a sawtooth never reports a peak
   assert_no_peak_saw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_peak |-> (mode_q == CAR_TRI));
   // R9: period and shape move only on a restart
   assert_period_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer.restart |=> ($stable(per_act) && $stable(mode_q)));
   // R10: event pulses are single-cycle and exclusive
   assert_evt_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valley && upd_peak));
   assert_evt_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valley || upd_peak) |=> !(upd_valley || upd_peak));
   // R2: without a selected tick the carrier holds
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             xfer,
   output logic [CNT_W-1:0] active
);

   logic [CNT_W-1:0] shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
      end else begin
         if (wr) begin
            shadow <= wdata;
         end
         if (xfer) begin
            active <= shadow;
         end
      end
   end

   // R5: active compare value moves only at an update instant
   assert_active_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(active));
   // R6: a write never lands in the active register on its own edge
   assert_write_via_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !xfer) |=> $stable(active));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] active,
   input  logic [CNT_W-1:0] per_act,
   output logic             pwm
);

   logic below;
   logic full_on;

   assign below   = (cnt < active);
   assign full_on = (active >= per_act);
   assign pwm     = below | full_on;

   // R8: a zero duty keeps the switch off
   always_comb begin
      assert_zero_duty_low_R8: assert (!(active == '0 && per_act != '0 && pwm));
   end

endmodule

// File: rtl/carrier_pwm.sv
module carrier_pwm
   import carrier_pwm_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int CNT_W   = 16,
   parameter int MIN_PER = 2,
   parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic               carrier_tri,
   input  logic [CNT_W-1:0]   period,
   input  logic [CNT_W-1:0]   duty,
   input  logic               duty_wr,
   output logic               pwm_out,
   output logic               upd_valley,
   output logic               upd_peak
);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("carrier_pwm: NUM_SRC must be at least 1");
   end
   if (CNT_W < 4 || CNT_W > 31) begin : g_bad_width
      $error("carrier_pwm: CNT_W must lie in 4..31");
   end
   if (MIN_PER < 2) begin : g_bad_min
      $error("carrier_pwm: MIN_PER must be at least 2");
   end
   if (SEL_W < $clog2(NUM_SRC)) begin : g_bad_sel
      $error("carrier_pwm: SEL_W too narrow for NUM_SRC");
   end

   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] active;
   upd_evt_t         xfer;

   pwm_tick_mux #(
      .NUM_SRC (NUM_SRC),
      .SEL_W   (SEL_W)
   ) i_tick_mux (
      .src_tick (src_tick),
      .sel      (src_sel),
      .tick     (tick)
   );

   pwm_carrier #(
      .CNT_W   (CNT_W),
      .MIN_PER (MIN_PER)
   ) i_carrier (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .tri_req    (carrier_tri),
      .period_req (period),
      .cnt        (cnt),
      .per_act    (per_act),
      .xfer       (xfer),
      .upd_valley (upd_valley),
      .upd_peak   (upd_peak)
   );

   pwm_duty_latch #(
      .CNT_W (CNT_W)
   ) i_duty_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (duty_wr),
      .wdata  (duty),
      .xfer   (xfer.restart | xfer.peak),
      .active (active)
   );

   pwm_compare #(
      .CNT_W (CNT_W)
   ) i_compare (
      .cnt     (cnt),
      .active  (active),
      .per_act (per_act),
      .pwm     (pwm_out)
   );

   // R1: quiet outputs during reset release
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!upd_valley && !upd_peak && !pwm_out));
   // R8: full-scale duty keeps the switch on across the whole period
   assert_full_duty_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active >= per_act) |-> pwm_out);

endmodule

// File: tb/test_carrier_pwm.sv
`timescale 1ns/1ps
module test_carrier_pwm;

   localparam int NSRC = 4;
   localparam int W    = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_tick = '0;
   logic [1:0]      src_sel = '0;
   logic            carrier_tri = 1'b0;
   logic [W-1:0]    period = 16'd2;
   logic [W-1:0]    duty = '0;
   logic            duty_wr = 1'b0;
   logic            pwm_out, upd_valley, upd_peak;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_k, m_P, m_act, m_sh;
   bit m_tri, e_val, e_peak;

   always #2.5 clk = ~clk;

   carrier_pwm i_carrier_pwm (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
      .carrier_tri(carrier_tri), .period(period), .duty(duty), .duty_wr(duty_wr),
      .pwm_out(pwm_out), .upd_valley(upd_valley), .upd_peak(upd_peak)
   );

   function automatic int carrier_val(int k, int P, bit tri_m);
      if (!tri_m) return k;
      return (k <= P) ? k : 2 * P - k;
   endfunction

   function automatic bit exp_pwm();
      return (carrier_val(m_k, m_P, m_tri) < m_act) || (m_act >= m_P);
   endfunction

   task automatic check1(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_k = 0; m_P = 2; m_tri = 0; m_act = 0; m_sh = 0; e_val = 0; e_peak = 0;
   endtask

   // called at a negedge: apply inputs, advance the model, wait, check
   task automatic cyc(string tag, logic [3:0] tk, logic [1:0] sel, bit tri_r,
                      int per, int dv, bit wr);
      bit hit;
      src_tick = tk; src_sel = sel; carrier_tri = tri_r;
      period = W'(per); duty = W'(dv); duty_wr = wr;
      e_val = 0; e_peak = 0;
      hit = tk[sel];
      if (hit) begin
         m_k++;
         if (!m_tri && m_k == m_P) begin
            e_val = 1;
         end else if (m_tri && m_k == m_P) begin
            e_peak = 1; m_act = m_sh;
         end else if (m_tri && m_k == 2 * m_P) begin
            e_val = 1;
         end
         if (e_val) begin
            m_k = 0; m_act = m_sh; m_tri = tri_r;
            m_P = (per < 2) ? 2 : per;
         end
      end
      if (wr) m_sh = dv;
      @(negedge clk);
      check1(tag, "pwm_out", int'(pwm_out), int'(exp_pwm()));
      check1(tag, "upd_valley", int'(upd_valley), int'(e_val));
      check1(tag, "upd_peak", int'(upd_peak), int'(e_peak));
   endtask

   task automatic run(string tag, int n, logic [3:0] tk, logic [1:0] sel,
                      bit tri_r, int per);
      for (int i = 0; i < n; i++) cyc(tag, tk, sel, tri_r, per, 0, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd13579;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      check1("R1", "pwm_out in reset", int'(pwm_out), 0);
      check1("R1", "upd_valley in reset", int'(upd_valley), 0);
      check1("R1", "upd_peak in reset", int'(upd_peak), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R1", "pwm_out after reset", int'(pwm_out), 0);

      // R3: sawtooth, P=5, duty 2 from source 0
      cyc("R3", 4'b0000, 2'd0, 0, 5, 2, 1);
      run("R3", 30, 4'b0001, 2'd0, 0, 5);

      // R2: ticks only on unselected sources leave everything frozen
      run("R2", 12, 4'b1101, 2'd1, 0, 5);
      run("R2", 10, 4'b0010, 2'd1, 0, 5);

      // R4: triangular, P=4, duty 3
      cyc("R4", 4'b0001, 2'd0, 1, 4, 3, 1);
      run("R4", 40, 4'b0001, 2'd0, 1, 4);

      // R5: writes mid-period in triangle mode, transfers at peak and valley
      for (int i = 0; i < 24; i++)
         cyc("R5", 4'b0100, 2'd2, 1, 4, (i % 5), (i % 3 == 0));

      // R6: back-to-back writes, last wins; a write on a transfer edge
      cyc("R6", 4'b0000, 2'd0, 1, 4, 1, 1);
      cyc("R6", 4'b0000, 2'd0, 1, 4, 4, 1);
      cyc("R6", 4'b0000, 2'd0, 1, 4, 2, 1);
      run("R6", 20, 4'b0001, 2'd0, 1, 4);
      for (int i = 0; i < 20; i++) cyc("R6", 4'b0001, 2'd0, 1, 4, i + 1, 1);

      // R8: duty extremes in both shapes
      cyc("R8", 4'b0000, 2'd0, 0, 6, 0, 1);
      run("R8", 30, 4'b0001, 2'd0, 0, 6);
      cyc("R8", 4'b0000, 2'd0, 0, 6, 6, 1);
      run("R8", 30, 4'b0001, 2'd0, 1, 6);
      cyc("R8", 4'b0000, 2'd0, 1, 6, 200, 1);
      run("R8", 40, 4'b0001, 2'd0, 1, 6);

      // R9: period and shape change requested mid-period; period below 2
      cyc("R9", 4'b0000, 2'd3, 0, 3, 2, 1);
      run("R9", 5, 4'b1000, 2'd3, 0, 3);
      run("R9", 30, 4'b1000, 2'd3, 0, 7);
      run("R9", 20, 4'b1000, 2'd3, 1, 0);

      // R7 / R10: seeded random mix, sparse ticks, reconfiguration
      for (int i = 0; i < 6000; i++) begin
         logic [3:0] tk;
         logic [1:0] sl;
         int per_r, d_r;
         bit tr, wr;
         tk    = 4'($urandom);
         sl    = 2'($urandom_range(0, 3));
         if (i % 400 < 200) sl = 2'd0;
         tr    = 1'($urandom);
         per_r = $urandom_range(0, 12);
         d_r   = $urandom_range(0, 15);
         wr    = ($urandom_range(0, 3) == 0);
         cyc((i < 3000) ? "R7" : "R10", tk, sl, tr, per_r, d_r, wr);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule